// File: doc/BRIEF.md
# Programmable Parallel Port Controller

A peripheral that sits on an 8-bit processor bus and drives three 8-bit general-purpose ports, named A, B and C. The processor reaches it through a select, a read strobe, a write strobe and a two-bit address. Three of the addresses reach the ports. The fourth takes a configuration word.

A configuration word does one of two things.

- It can set the direction of port A, port B, the upper nibble of port C and the lower nibble of port C. This clears every output latch.
- It can force a single port C latch bit to 0 or 1, leaving the other seven bits and all directions untouched.

Port A and the upper half of port C form one control group. Port B and the lower half of port C form the other.

The ports always run as plain input/output, with no handshaking and no interrupts. Configuration bits that would choose handshaking or bidirectional operation are accepted and have no effect.

Writes take effect at the clock edge. Reads are combinational while select and read are both high.

Top module: `pport_ctrl`

## Requirements
- R1: After reset, every port is an input: all `*_oe` bits are 0 and all output latches (`pa_out`, `pb_out`, `pc_out`) are 0.
- R2: A write with `sel`=1 and `wr`=1 stores `wdata` into the latch chosen by `addr`. Address 0 selects port A, 1 selects port B and 2 selects port C. The stored value appears on that port's output one clock edge later.
- R3: A write to address 3 with `wdata[7]`=1 is a mode word, where a direction bit of 1 means input. Bit 4 sets the direction of port A, bit 3 of port C bits 7..4, bit 1 of port B, and bit 0 of port C bits 3..0. An output port drives all ones on its `*_oe` bits.
- R4: A mode word clears all three output latches to 0.
- R5: A write to address 3 with `wdata[7]`=0 sets port C latch bit `wdata[3:1]` to the value of `wdata[0]`. The other port C bits, ports A and B, and all directions are unchanged.
- R6: Reading a port, or a port C nibble, that is set as input returns the live pin value.
- R7: Reading a port, or a port C nibble, that is set as output returns its output latch.
- R8: `bus_en` is high and `rdata` carries data only while `sel` and `rd` are both 1. At all other times `rdata` is 0. Reading address 3 returns 0.
- R9: Write strobes with `sel`=0 change no latch and no direction.
- R10: Mode-word bits 6, 5 and 2 have no effect: the ports behave as plain input/output whatever their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 2 | Target: 0 = A, 1 = B, 2 = C, 3 = control |
| wdata | input | 8 | Write data from the processor |
| rdata | output | 8 | Read data to the processor, 0 when idle |
| bus_en | output | 1 | High while the block drives the data bus |
| pa_pin | input | 8 | Port A pin levels |
| pb_pin | input | 8 | Port B pin levels |
| pc_pin | input | 8 | Port C pin levels |
| pa_out | output | 8 | Port A output latch |
| pb_out | output | 8 | Port B output latch |
| pc_out | output | 8 | Port C output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_oe | output | 8 | Port B output enables |
| pc_oe | output | 8 | Port C output enables |

## Verification
The bench sweeps all sixteen direction combinations, with and without the ignored mode bits set, and reads every port back against distinct pin and latch patterns.

- A design that swapped a direction bit, or split port C at the wrong nibble, would return a latch where a pin is expected.
- A design that failed to clear the latches on a mode word would show the previous data on the outputs.

Every one of the sixteen set/reset commands is issued over a known port C pattern. A wrong bit index, or a disturbed neighbour bit, shows up on `pc_out`. So would a direction change caused by the command.

The bench also issues unselected writes, idle reads and reads of the control address. These catch a bus that drives when it should not, and latches that move without a select.

// File: rtl/pport_ctrl.sv
module pport_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       rd,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       bus_en,
  input  logic [7:0] pa_pin,
  input  logic [7:0] pb_pin,
  input  logic [7:0] pc_pin,
  output logic [7:0] pa_out,
  output logic [7:0] pb_out,
  output logic [7:0] pc_out,
  output logic [7:0] pa_oe,
  output logic [7:0] pb_oe,
  output logic [7:0] pc_oe
);

  logic [7:0] lat_a, lat_b, lat_c;
  logic       in_a, in_b, in_cu, in_cl;
  logic [7:0] mux_c;
  logic       wr_go;

  assign wr_go = sel && wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_a <= '0; lat_b <= '0; lat_c <= '0;
      in_a  <= 1'b1; in_b <= 1'b1; in_cu <= 1'b1; in_cl <= 1'b1;
    end else if (wr_go) begin
      case (addr)
        2'd0: lat_a <= wdata;
        2'd1: lat_b <= wdata;
        2'd2: lat_c <= wdata;
        default:
          if (wdata[7]) begin
            in_a  <= wdata[4];
            in_cu <= wdata[3];
            in_b  <= wdata[1];
            in_cl <= wdata[0];
            lat_a <= '0; lat_b <= '0; lat_c <= '0;
          end else begin
            lat_c[wdata[3:1]] <= wdata[0];
          end
      endcase
    end
  end

  assign pa_out = lat_a;
  assign pb_out = lat_b;
  assign pc_out = lat_c;
  assign pa_oe  = {8{~in_a}};
  assign pb_oe  = {8{~in_b}};
  assign pc_oe  = {{4{~in_cu}}, {4{~in_cl}}};

  assign mux_c  = {in_cu ? pc_pin[7:4] : lat_c[7:4], in_cl ? pc_pin[3:0] : lat_c[3:0]};
  assign bus_en = sel && rd;

  always_comb begin
    rdata = '0;
    if (bus_en) begin
      case (addr)
        2'd0:    rdata = in_a ? pa_pin : lat_a;
        2'd1:    rdata = in_b ? pb_pin : lat_b;
        2'd2:    rdata = mux_c;
        default: rdata = '0;
      endcase
    end
  end

  a_r4_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && addr == 2'd3 && wdata[7]) |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

  a_r5_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && addr == 2'd3 && !wdata[7]) |=> ($countones(pc_out ^ $past(pc_out)) <= 1 && $stable(pa_out) && $stable(pb_out)));

  a_r5_dirs_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && addr == 2'd3 && !wdata[7]) |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  a_r9_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_go |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) && $stable(pc_oe) && $stable(pa_oe)));

  a_r8_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && rd) |-> (rdata == 8'h00));

endmodule

// File: tb/test_pport_ctrl.sv
module test_pport_ctrl;
  logic clk = 0, rst_n = 0, sel = 0, rd = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, pa_pin = 0, pb_pin = 0, pc_pin = 0;
  logic [7:0] rdata, pa_out, pb_out, pc_out, pa_oe, pb_oe, pc_oe;
  logic bus_en;
  int tests = 0, fails = 0;
  bit done = 0;

  pport_ctrl i_pport_ctrl (.clk, .rst_n, .sel, .rd, .wr, .addr, .wdata, .rdata, .bus_en,
    .pa_pin, .pb_pin, .pc_pin, .pa_out, .pb_out, .pc_out, .pa_oe, .pb_oe, .pc_oe);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [1:0] a, input logic [7:0] d, input logic s);
    @(negedge clk); sel = s; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bread(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; rd = 1; addr = a; #2;
    d = rdata;
    chk("R8 bus_en", {7'd0, bus_en}, 8'd1);
    sel = 0; rd = 0;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, lc, ec;
    pa_pin = 8'h5A; pb_pin = 8'hC3; pc_pin = 8'h96;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", pa_oe | pb_oe | pc_oe, 8'h00);
    chk("R1 latch", pa_out | pb_out | pc_out, 8'h00);
    bread(2'd0, v); chk("R6 reset read A", v, 8'h5A);
    bread(2'd3, v); chk("R8 control read", v, 8'h00);
    #2; chk("R8 idle rdata", rdata, 8'h00);
    chk("R8 idle bus_en", {7'd0, bus_en}, 8'h00);

    for (int k = 0; k < 32; k++) begin
      logic ia, icu, ib, icl;
      logic [7:0] mw, da, db, dc;
      ia = k[3]; icu = k[2]; ib = k[1]; icl = k[0];
      mw = 8'h80 | {3'b0, ia, icu, 1'b0, ib, icl};
      if (k >= 16) mw = mw | 8'h64; // R10 ignored bits
      pa_pin = 8'h11 * k[3:0]; pb_pin = ~pa_pin; pc_pin = 8'hA5 ^ {4'(k), 4'(k)};
      bwrite(2'd0, 8'hFF, 1); bwrite(2'd2, 8'hFF, 1);
      bwrite(2'd3, mw, 1);
      chk("R4 clear A", pa_out, 8'h00);
      chk("R4 clear C", pc_out, 8'h00);
      chk("R3 oe A", pa_oe, {8{~ia}});
      chk("R3 oe B", pb_oe, {8{~ib}});
      chk("R3 oe C", pc_oe, {{4{~icu}}, {4{~icl}}});
      da = 8'h3C + 8'(k); db = 8'hE1 ^ 8'(k); dc = 8'h69 + 8'(3 * k);
      bwrite(2'd0, da, 1); bwrite(2'd1, db, 1); bwrite(2'd2, dc, 1);
      chk("R2 latch A", pa_out, da);
      chk("R2 latch B", pb_out, db);
      chk("R2 latch C", pc_out, dc);
      bread(2'd0, v); chk(ia ? "R6 read A" : "R7 read A", v, ia ? pa_pin : da);
      bread(2'd1, v); chk(ib ? "R6 read B" : "R7 read B", v, ib ? pb_pin : db);
      bread(2'd2, v);
      ec = {icu ? pc_pin[7:4] : dc[7:4], icl ? pc_pin[3:0] : dc[3:0]};
      chk("R6/R7 R10 read C", v, ec);
      // R9 unselected writes ignored
      bwrite(2'd0, ~da, 0); bwrite(2'd3, 8'h9B, 0); bwrite(2'd2, ~dc, 0);
      chk("R9 A kept", pa_out, da);
      chk("R9 C kept", pc_out, dc);
      chk("R9 oe kept", pc_oe, {{4{~icu}}, {4{~icl}}});
    end

    // R5 single-bit set/reset sweep
    bwrite(2'd3, 8'h80, 1);
    bwrite(2'd0, 8'h77, 1);
    lc = 8'hB4;
    bwrite(2'd2, lc, 1);
    for (int n = 0; n < 16; n++) begin
      logic [2:0] bi;
      logic bv;
      bi = 3'(n >> 1); bv = ~lc[bi];
      bwrite(2'd3, {4'b0, bi, bv}, 1);
      lc[bi] = bv;
      chk("R5 bit", pc_out, lc);
      chk("R5 A kept", pa_out, 8'h77);
      chk("R5 dirs kept", pc_oe | pa_oe, 8'hFF);
      bread(2'd2, v); chk("R5 read C", v, lc);
    end
    bwrite(2'd3, 8'h0F, 1); lc[7] = 1;
    chk("R5 set bit 7", pc_out, lc);
    bwrite(2'd3, 8'h00, 1); lc[0] = 0;
    chk("R5 clear bit 0", pc_out, lc);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule